// File: doc/BRIEF.md
# Multi-Mode Infrared Link Interrupt Controller

This block gathers the event pulses of an infrared link controller into sticky status bits and drives one registered interrupt line. The link has a slow mode and a pair of faster modes (medium and fast). Each kind of mode owns its own status group and its own per-bit mask register. A shared control register holds the current transfer mode and three master mask bits: one for each status group and one for a FIFO receive flag.

A single vector of five event pulses comes from the link logic. The same vector reaches both groups, but only the group that matches the current transfer mode records it. The meaning of two bit positions therefore depends on the mode. In the slow group they are timeout and framing error. In the fast group they are abort and CRC error. Software reads a status register and writes the same value to the matching clear register to acknowledge the events. A plain 16-bit register port with a combinational read path gives access to every register.

Top module: `irx_intc`

## Requirements
- R1: After reset, both status registers and the FIFO flag read 0, both mask registers read 0x8B80, the control register reads 0x0111 (slow mode, all three master masks set), and `irq_o` is 0.
- R2: Each event input lands on a fixed status bit. `evt_i[0]` frame transmitted goes to bit 7. `evt_i[1]` framing/CRC error goes to bit 8. `evt_i[2]` timeout/abort goes to bit 9. `evt_i[3]` buffer overflow goes to bit 11. `evt_i[4]` frame received goes to bit 15.
- R3: The control register's mode field is bits 15:14, coded 00 slow, 11 medium, 10 fast, 01 reserved. The slow group (status at address 1) records events only in mode 00. The fast group (status at address 4) records events only in modes 11 and 10. In mode 01 neither group records.
- R4: A write to a clear register clears each status bit whose written bit is 1 and leaves the others. The clear registers are address 3 (slow) and 6 (fast), and they read as 0.
- R5: An event that arrives in the same cycle as a clear write to its bit leaves that bit set.
- R6: A mask bit of 1 keeps the matching status bit from raising the interrupt. The status bit is still recorded. The mask registers are at address 2 (slow) and 5 (fast).
- R7: Control bit 0 blocks the whole slow group from the interrupt. Bit 4 blocks the fast group and bit 8 blocks the FIFO flag. Status is kept while a group is blocked.
- R8: `irq_o` is registered. It rises or falls on the clock edge after the one that changes the status, mask or control state behind it.
- R9: A `fifo_evt_i` pulse sets bit 0 of address 7 in any mode. Writing 1 to that bit clears it, and writing 0 has no effect.
- R10: Mask registers keep only bits 15, 11, 9, 8 and 7. The control register keeps only bits 15:14, 8, 4 and 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| evt_i | input | 5 | Link event pulses, one cycle each |
| fifo_evt_i | input | 1 | FIFO receive event pulse |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A link event and a software clear write to the same status bit can fall in the same clock cycle. That is the race this block must settle. The bench raises an event pulse in the very cycle it writes all ones to the clear register. Afterwards it reads the status back. The bit carried by the event must still be set, and every other bit must be clear. A clocked property checks the same rule on every such cycle of the run.

// File: rtl/irx_pkg.sv
package irx_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned EVT_N  = 5;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned GRP_N  = 2;
    localparam int unsigned REG_N  = 2 ** ADDR_W;

    typedef enum logic [1:0] {
        XM_SLOW = 2'b00,
        XM_RSVD = 2'b01,
        XM_FAST = 2'b10,
        XM_MED  = 2'b11
    } xfer_mode_e;

    // control register field positions
    localparam int unsigned CTL_MODE_LO = 14;
    localparam int unsigned CTL_MM_SLOW = 0;
    localparam int unsigned CTL_MM_FAST = 4;
    localparam int unsigned CTL_MM_FIFO = 8;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_SL_ST  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SL_MSK = 3'd2;
    localparam logic [ADDR_W-1:0] A_SL_CLR = 3'd3;
    localparam logic [ADDR_W-1:0] A_FA_ST  = 3'd4;
    localparam logic [ADDR_W-1:0] A_FA_MSK = 3'd5;
    localparam logic [ADDR_W-1:0] A_FA_CLR = 3'd6;
    localparam logic [ADDR_W-1:0] A_FIFO   = 3'd7;

    // status bit taken by each event input
    function automatic int unsigned evt_bit(int unsigned idx);
        case (idx)
            0:       return 7;
            1:       return 8;
            2:       return 9;
            3:       return 11;
            default: return 15;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] place_evts(logic [EVT_N-1:0] e);
        logic [REG_W-1:0] w;
        w = '0;
        for (int unsigned i = 0; i < EVT_N; i++) begin
            w[evt_bit(i)] = e[i];
        end
        return w;
    endfunction

    localparam logic [REG_W-1:0] IMPL_BITS = place_evts('1);

    // base address of each status group: status, mask, clear follow
    function automatic logic [ADDR_W-1:0] grp_base(int unsigned g);
        return (g == 0) ? A_SL_ST : A_FA_ST;
    endfunction

endpackage

// File: rtl/irx_evt_group.sv
module irx_evt_group
    import irx_pkg::*;
#(
    parameter int unsigned      W    = REG_W,
    parameter int unsigned      N    = EVT_N,
    parameter logic [W-1:0]     IMPL = IMPL_BITS
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] evt_i,
    input  logic         rec_en_i,
    input  logic         mask_we_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);

    typedef struct packed {
        logic [W-1:0] st;
        logic [W-1:0] msk;
    } grp_s;

    grp_s grp_d, grp_q;
    logic [W-1:0] evt_w;
    logic [W-1:0] clr_w;

    always_comb begin
        evt_w = rec_en_i ? W'(place_evts(EVT_N'(evt_i))) : '0;
        clr_w = clr_we_i ? wdata_i : '0;
        grp_d = grp_q;
        // an arriving event overrides a simultaneous clear
        grp_d.st = ((grp_q.st & ~clr_w) | evt_w) & IMPL;
        if (mask_we_i) begin
            grp_d.msk = wdata_i & IMPL;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            grp_q.st  <= '0;
            grp_q.msk <= IMPL;
        end else begin
            grp_q <= grp_d;
        end
    end

    assign status_o = grp_q.st;
    assign mask_o   = grp_q.msk;
    assign pend_o   = |(grp_q.st & ~grp_q.msk);

endmodule

// File: rtl/irx_ctrl_reg.sv
module irx_ctrl_reg
    import irx_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ctrl_we_i,
    input  logic         fifo_clr_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         fifo_evt_i,
    output xfer_mode_e   mode_o,
    output logic         mm_slow_o,
    output logic         mm_fast_o,
    output logic         mm_fifo_o,
    output logic         fifo_flag_o,
    output logic         rec_slow_o,
    output logic         rec_fast_o,
    output logic [W-1:0] ctrl_word_o
);

    typedef struct packed {
        xfer_mode_e mode;
        logic       mm_fifo;
        logic       mm_fast;
        logic       mm_slow;
        logic       fifo;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctrl_we_i) begin
            ctl_d.mode    = xfer_mode_e'(wdata_i[CTL_MODE_LO +: 2]);
            ctl_d.mm_fifo = wdata_i[CTL_MM_FIFO];
            ctl_d.mm_fast = wdata_i[CTL_MM_FAST];
            ctl_d.mm_slow = wdata_i[CTL_MM_SLOW];
        end
        ctl_d.fifo = (ctl_q.fifo & ~(fifo_clr_we_i & wdata_i[0])) | fifo_evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.mode    <= XM_SLOW;
            ctl_q.mm_fifo <= 1'b1;
            ctl_q.mm_fast <= 1'b1;
            ctl_q.mm_slow <= 1'b1;
            ctl_q.fifo    <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        ctrl_word_o = '0;
        ctrl_word_o[CTL_MODE_LO +: 2] = ctl_q.mode;
        ctrl_word_o[CTL_MM_FIFO]      = ctl_q.mm_fifo;
        ctrl_word_o[CTL_MM_FAST]      = ctl_q.mm_fast;
        ctrl_word_o[CTL_MM_SLOW]      = ctl_q.mm_slow;
    end

    assign mode_o      = ctl_q.mode;
    assign mm_slow_o   = ctl_q.mm_slow;
    assign mm_fast_o   = ctl_q.mm_fast;
    assign mm_fifo_o   = ctl_q.mm_fifo;
    assign fifo_flag_o = ctl_q.fifo;
    assign rec_slow_o  = (ctl_q.mode == XM_SLOW);
    assign rec_fast_o  = (ctl_q.mode == XM_MED) || (ctl_q.mode == XM_FAST);

endmodule

// File: rtl/irx_bus_dec.sv
module irx_bus_dec
    import irx_pkg::*;
#(
    parameter int unsigned W  = REG_W,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned NR = REG_N
) (
    input  logic          wr_en_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  ctrl_word_i,
    input  logic [W-1:0]  sl_st_i,
    input  logic [W-1:0]  sl_msk_i,
    input  logic [W-1:0]  fa_st_i,
    input  logic [W-1:0]  fa_msk_i,
    input  logic          fifo_flag_i,
    output logic [NR-1:0] we_o,
    output logic [W-1:0]  rdata_o
);

    for (genvar i = 0; i < NR; i++) begin : g_we
        assign we_o[i] = wr_en_i && (addr_i == AW'(i));
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL:   rdata_o = ctrl_word_i;
            A_SL_ST:  rdata_o = sl_st_i;
            A_SL_MSK: rdata_o = sl_msk_i;
            A_FA_ST:  rdata_o = fa_st_i;
            A_FA_MSK: rdata_o = fa_msk_i;
            A_FIFO:   rdata_o = {{(W-1){1'b0}}, fifo_flag_i};
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irx_irq_merge.sv
module irx_irq_merge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pend_slow_i,
    input  logic pend_fast_i,
    input  logic fifo_flag_i,
    input  logic mm_slow_i,
    input  logic mm_fast_i,
    input  logic mm_fifo_i,
    output logic irq_o
);

    typedef struct packed {
        logic irq;
    } irq_s;

    irq_s irq_d, irq_q;

    always_comb begin
        irq_d.irq = (pend_slow_i & ~mm_slow_i)
                  | (pend_fast_i & ~mm_fast_i)
                  | (fifo_flag_i & ~mm_fifo_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q.irq;

endmodule

// File: rtl/irx_intc.sv
module irx_intc
    import irx_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic [EVT_N-1:0]  evt_i,
    input  logic              fifo_evt_i,
    output logic              irq_o
);

    logic [REG_N-1:0] we;
    logic [REG_W-1:0] grp_st  [GRP_N];
    logic [REG_W-1:0] grp_msk [GRP_N];
    logic             grp_pend[GRP_N];
    logic             grp_rec [GRP_N];

    xfer_mode_e       mode;
    logic             mm_slow, mm_fast, mm_fifo, fifo_flag;
    logic             rec_slow, rec_fast;
    logic [REG_W-1:0] ctrl_word;
    logic [REG_W-1:0] sl_st, sl_msk, fa_st, fa_msk;

    irx_ctrl_reg u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .ctrl_we_i    (we[A_CTRL]),
        .fifo_clr_we_i(we[A_FIFO]),
        .wdata_i      (wdata_i),
        .fifo_evt_i   (fifo_evt_i),
        .mode_o       (mode),
        .mm_slow_o    (mm_slow),
        .mm_fast_o    (mm_fast),
        .mm_fifo_o    (mm_fifo),
        .fifo_flag_o  (fifo_flag),
        .rec_slow_o   (rec_slow),
        .rec_fast_o   (rec_fast),
        .ctrl_word_o  (ctrl_word)
    );

    assign grp_rec[0] = rec_slow;
    assign grp_rec[1] = rec_fast;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] BASE = grp_base(g);
        irx_evt_group u_grp (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .evt_i    (evt_i),
            .rec_en_i (grp_rec[g]),
            .mask_we_i(we[BASE + ADDR_W'(1)]),
            .clr_we_i (we[BASE + ADDR_W'(2)]),
            .wdata_i  (wdata_i),
            .status_o (grp_st[g]),
            .mask_o   (grp_msk[g]),
            .pend_o   (grp_pend[g])
        );
    end

    assign sl_st  = grp_st[0];
    assign sl_msk = grp_msk[0];
    assign fa_st  = grp_st[1];
    assign fa_msk = grp_msk[1];

    irx_bus_dec u_dec (
        .wr_en_i    (wr_en_i),
        .addr_i     (addr_i),
        .ctrl_word_i(ctrl_word),
        .sl_st_i    (sl_st),
        .sl_msk_i   (sl_msk),
        .fa_st_i    (fa_st),
        .fa_msk_i   (fa_msk),
        .fifo_flag_i(fifo_flag),
        .we_o       (we),
        .rdata_o    (rdata_o)
    );

    irx_irq_merge u_irq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pend_slow_i(grp_pend[0]),
        .pend_fast_i(grp_pend[1]),
        .fifo_flag_i(fifo_flag),
        .mm_slow_i  (mm_slow),
        .mm_fast_i  (mm_fast),
        .mm_fifo_i  (mm_fifo),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/irx_intc_chk.sv
module irx_intc_chk
    import irx_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [EVT_N-1:0]  evt_i,
    input xfer_mode_e        mode,
    input logic [REG_W-1:0]  sl_st,
    input logic [REG_W-1:0]  sl_msk,
    input logic [REG_W-1:0]  fa_st,
    input logic [REG_W-1:0]  fa_msk,
    input logic              mm_slow,
    input logic              mm_fast,
    input logic              mm_fifo,
    input logic              fifo_flag,
    input logic              irq_o
);

    assert_evt_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == A_SL_CLR && mode == XM_SLOW)
        |=> ((sl_st & $past(place_evts(evt_i))) == $past(place_evts(evt_i))));

    assert_slow_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode != XM_SLOW && !(wr_en_i && addr_i == A_SL_CLR)) |=> $stable(sl_st));

    assert_fast_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((mode == XM_SLOW || mode == XM_RSVD) && !(wr_en_i && addr_i == A_FA_CLR))
        |=> $stable(fa_st));

    assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((sl_st & ~$past(sl_st | place_evts(evt_i))) == '0));

    assert_irq_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((((sl_st & ~sl_msk) == '0) || mm_slow) &&
         (((fa_st & ~fa_msk) == '0) || mm_fast) &&
         (!fifo_flag || mm_fifo)) |=> !irq_o);

    assert_irq_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (((sl_st & ~sl_msk) != '0) && !mm_slow) |=> irq_o);

    assert_mask_bits_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sl_msk & ~IMPL_BITS) == '0) && ((fa_msk & ~IMPL_BITS) == '0));

endmodule

bind irx_intc irx_intc_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .evt_i    (evt_i),
    .mode     (mode),
    .sl_st    (sl_st),
    .sl_msk   (sl_msk),
    .fa_st    (fa_st),
    .fa_msk   (fa_msk),
    .mm_slow  (mm_slow),
    .mm_fast  (mm_fast),
    .mm_fifo  (mm_fifo),
    .fifo_flag(fifo_flag),
    .irq_o    (irq_o)
);

// File: tb/sim_irx_intc.sv
module sim_irx_intc;

    localparam time CLK_PERIOD = 10ns;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic [4:0]  evt_i = '0;
    logic        fifo_evt_i = 1'b0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    irx_intc u0 (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .evt_i     (evt_i),
        .fifo_evt_i(fifo_evt_i),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk_i);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk_i);
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk_i);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic pulse(input logic [4:0] e);
        @(negedge clk_i);
        evt_i = e;
        @(negedge clk_i);
        evt_i = '0;
    endtask

    task automatic pulse_fifo();
        @(negedge clk_i);
        fifo_evt_i = 1'b1;
        @(negedge clk_i);
        fifo_evt_i = 1'b0;
    endtask

    task automatic clr_all();
        wr(3'd3, 16'hFFFF);
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'h0001);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); check("R1 ctrl", v, 16'h0111);
        rd(3'd1, v); check("R1 slow status", v, 16'h0000);
        rd(3'd2, v); check("R1 slow mask", v, 16'h8B80);
        rd(3'd4, v); check("R1 fast status", v, 16'h0000);
        rd(3'd5, v); check("R1 fast mask", v, 16'h8B80);
        rd(3'd7, v); check("R1 fifo flag", v, 16'h0000);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_positions();
        logic [15:0] v;
        logic [15:0] pos [5] = '{16'h0080, 16'h0100, 16'h0200, 16'h0800, 16'h8000};
        wr(3'd0, 16'h0111);
        for (int i = 0; i < 5; i++) begin
            pulse(5'(1 << i));
            rd(3'd1, v); check("R2 event bit position", v, pos[i]);
            rd(3'd4, v); check("R3 fast idle in slow mode", v, 16'h0000);
            wr(3'd3, 16'hFFFF);
        end
    endtask

    task automatic t_mode_gate();
        logic [15:0] v;
        clr_all();
        wr(3'd0, 16'hC111);
        pulse(5'h1F);
        rd(3'd4, v); check("R3 medium records fast", v, 16'h8B80);
        rd(3'd1, v); check("R3 medium skips slow", v, 16'h0000);
        wr(3'd6, 16'hFFFF);
        wr(3'd0, 16'h8111);
        pulse(5'h02);
        rd(3'd4, v); check("R3 fast mode records", v, 16'h0100);
        wr(3'd6, 16'hFFFF);
        wr(3'd0, 16'h4111);
        rd(3'd0, v); check("R3 reserved mode readback", v, 16'h4111);
        pulse(5'h1F);
        rd(3'd1, v); check("R3 reserved slow", v, 16'h0000);
        rd(3'd4, v); check("R3 reserved fast", v, 16'h0000);
        wr(3'd0, 16'h0111);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        clr_all();
        pulse(5'h1F);
        rd(3'd1, v); check("R4 all set", v, 16'h8B80);
        wr(3'd3, 16'h0880);
        rd(3'd1, v); check("R4 partial clear", v, 16'h8300);
        rd(3'd3, v); check("R4 clear reads zero", v, 16'h0000);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        // status holds 0x8300 from the previous scenario
        @(negedge clk_i);
        addr_i = 3'd3; wdata_i = 16'hFFFF; wr_en_i = 1'b1; evt_i = 5'h10;
        @(negedge clk_i);
        wr_en_i = 1'b0; wdata_i = '0; evt_i = '0;
        rd(3'd1, v); check("R5 event beats clear", v, 16'h8000);
        clr_all();
    endtask

    task automatic t_irq();
        logic [15:0] v;
        clr_all();
        wr(3'd0, 16'h0110);
        pulse(5'h01);
        @(negedge clk_i);
        check("R6 masked bit no irq", {15'd0, irq_o}, 16'h0000);
        rd(3'd1, v); check("R6 masked bit recorded", v, 16'h0080);
        wr(3'd2, 16'h8B00);
        check("R8 irq not yet after unmask", {15'd0, irq_o}, 16'h0000);
        @(negedge clk_i);
        check("R8 irq one cycle after unmask", {15'd0, irq_o}, 16'h0001);
        wr(3'd3, 16'h0080);
        @(negedge clk_i);
        check("R8 irq drops after clear", {15'd0, irq_o}, 16'h0000);
        pulse(5'h01);
        check("R8 irq not yet after event", {15'd0, irq_o}, 16'h0000);
        @(negedge clk_i);
        check("R8 irq one cycle after event", {15'd0, irq_o}, 16'h0001);
        wr(3'd2, 16'h8B80);
        clr_all();
    endtask

    task automatic t_master();
        logic [15:0] v;
        clr_all();
        wr(3'd0, 16'h0110);
        wr(3'd2, 16'h0000);
        pulse(5'h04);
        @(negedge clk_i);
        check("R7 slow open irq", {15'd0, irq_o}, 16'h0001);
        wr(3'd0, 16'h0111);
        @(negedge clk_i);
        check("R7 slow master blocks", {15'd0, irq_o}, 16'h0000);
        rd(3'd1, v); check("R7 status kept", v, 16'h0200);
        wr(3'd0, 16'hC101);
        wr(3'd5, 16'h0000);
        pulse(5'h08);
        @(negedge clk_i);
        check("R7 fast open irq", {15'd0, irq_o}, 16'h0001);
        rd(3'd4, v); check("R7 fast status", v, 16'h0800);
        wr(3'd0, 16'hC111);
        @(negedge clk_i);
        check("R7 fast master blocks", {15'd0, irq_o}, 16'h0000);
        wr(3'd0, 16'h0111);
        wr(3'd2, 16'h8B80);
        wr(3'd5, 16'h8B80);
        clr_all();
    endtask

    task automatic t_fifo();
        logic [15:0] v;
        clr_all();
        wr(3'd0, 16'h0011);
        pulse_fifo();
        rd(3'd7, v); check("R9 fifo flag set", v, 16'h0001);
        @(negedge clk_i);
        check("R7 fifo open irq", {15'd0, irq_o}, 16'h0001);
        wr(3'd0, 16'h0111);
        @(negedge clk_i);
        check("R7 fifo master blocks", {15'd0, irq_o}, 16'h0000);
        wr(3'd7, 16'h0000);
        rd(3'd7, v); check("R9 write zero keeps flag", v, 16'h0001);
        wr(3'd7, 16'h0001);
        rd(3'd7, v); check("R9 write one clears flag", v, 16'h0000);
    endtask

    task automatic t_unimpl();
        logic [15:0] v;
        wr(3'd2, 16'hFFFF);
        rd(3'd2, v); check("R10 slow mask bits", v, 16'h8B80);
        wr(3'd5, 16'h7FFF);
        rd(3'd5, v); check("R10 fast mask bits", v, 16'h0B80);
        wr(3'd0, 16'hFFFF);
        rd(3'd0, v); check("R10 ctrl bits", v, 16'hC111);
        wr(3'd0, 16'h0111);
        wr(3'd5, 16'h8B80);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_positions();
        t_mode_gate();
        t_clear();
        t_same_cycle();
        t_irq();
        t_master();
        t_fifo();
        t_unimpl();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule